// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates six interrupt sources for a small processor core. The sources are two active-low external pins, three timer overflow sources and one serial-port source. Each source has an enable bit and a priority bit that picks one of two levels. A global enable gates all of them. The external pins are latched inside the block, each either as a low level or as a falling edge. Overflow pulses from the first two timers are held in flags here. The serial and third-timer requests come in as flags that are held elsewhere and cleared by software.

From the latched flags the controller forms a request and a 16-bit handler address, both combinationally. When the core is ready to vector it pulses an acknowledge. The controller then marks the level of the chosen source as in service and clears that source's flag where hardware clearing applies. A return pulse retires the most recent level. The core also reports when it is in the last cycle of an instruction, and when the current instruction is a return or an access to the enable or priority settings. The request is held off until the core is in a last cycle and that instruction is neither a return nor such an access.

Top module: `irq2_ctrl`

## Requirements
- R1: Source index k (0 = external pin 0, 1 = timer 0, 2 = external pin 1, 3 = timer 1, 4 = serial, 5 = timer 2) vectors to VEC_BASE + 8*k, giving 0003h, 000Bh, 0013h, 001Bh, 0023h and 002Bh. `irq_vec` is 0 whenever `irq_req` is low.
- R2: A source can raise `irq_req` only when `master_en` is 1 and its own bit k of `src_en` is 1.
- R3: When several eligible sources are pending, any source whose bit in `src_hi` is 1 (high level) wins over every low-level source. Within one level, the lowest index wins.
- R4: While `insvc[0]` (low level) is set, only high-level sources may raise a request. While `insvc[1]` (high level) is set, no source may raise a request.
- R5: With `ext_edge[i]`=0 (level mode), a low on `ext_n[i]` at a clock edge sets that source's flag, and a high clears it. An acknowledge of that source clears the flag for one edge. If the pin is still low, the flag sets again at the next edge.
- R6: With `ext_edge[i]`=1 (edge mode), a high-to-low change of `ext_n[i]` between two edges sets the flag. The flag stays set after the pin goes high again, until that source is acknowledged.
- R7: A one-cycle pulse on `tmr_ovf[j]` (j = 0 or 1) sets the flag of timer j. The flag is cleared only when that timer's source is acknowledged.
- R8: `ser_req` and `t2_req` are used as given and are never cleared by this block. An acknowledged serial request therefore requests again once it is eligible.
- R9: `irq_req` is low whenever `last_cycle` is 0 or `ret_or_cfg` is 1.
- R10: An `irq_ack` that arrives while `irq_req` is high sets `insvc[1]` if the chosen source is high level, otherwise `insvc[0]`. An `irq_ret` clears `insvc[1]` if it is set, otherwise `insvc[0]`. With neither pulse, `insvc` holds.
- R11: After reset `insvc` is 00, all internal flags are clear and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Global interrupt enable |
| src_en | input | 6 | Per-source enable, indexed as in R1 |
| src_hi | input | 6 | Per-source priority, 1 = high level |
| ext_n | input | 2 | External request pins, active low |
| ext_edge | input | 2 | Trigger mode per pin, 1 = falling edge, 0 = low level |
| tmr_ovf | input | 2 | Overflow pulses of timers 0 and 1 |
| ser_req | input | 1 | Serial-port request flag (cleared by software) |
| t2_req | input | 1 | Timer 2 request flag (cleared by software) |
| last_cycle | input | 1 | Current instruction is in its last cycle |
| ret_or_cfg | input | 1 | Current instruction is a return or touches enable/priority settings |
| irq_ack | input | 1 | Vectoring acknowledge pulse |
| irq_ret | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Handler address of the winning source |
| insvc | output | 2 | In-service bits: [1] high level, [0] low level |

## Verification
A wrong in-service bit shows up at the ports in the same cycle. It either blocks a request that should be visible or lets through a request that should be blocked, so each acknowledge and return step is followed by a request/vector check. A flag that is cleared when it should not be, or not cleared when it should be, only becomes visible once the in-service level is retired. For that reason every clearing rule is checked on the first cycle after the matching return. Errors in edge capture show up one edge after the pin transition, and the bench samples exactly there.

// File: rtl/irq2_pkg.sv
package irq2_pkg;
   localparam int unsigned SRC_N = 6;
   localparam int unsigned IDX_W = 3;

   // fixed source slots; the index is also the polling rank
   typedef enum logic [IDX_W-1:0] {
      SRC_X0  = 3'd0,
      SRC_TM0 = 3'd1,
      SRC_X1  = 3'd2,
      SRC_TM1 = 3'd3,
      SRC_SER = 3'd4,
      SRC_TM2 = 3'd5
   } src_e;

   typedef struct packed {
      logic             hit;
      logic [IDX_W-1:0] idx;
      logic             lvl;
   } pick_t;
endpackage

// File: rtl/irq2_ext_latch.sv
module irq2_ext_latch #(
   parameter int unsigned N_PIN = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_PIN-1:0] pin_n,
   input  logic [N_PIN-1:0] edge_mode,
   input  logic [N_PIN-1:0] clr,
   output logic [N_PIN-1:0] flag
);
   generate
      if (N_PIN < 1) begin : g_bad
         $error("irq2_ext_latch: N_PIN must be at least 1");
      end
   endgenerate

   logic [N_PIN-1:0] pin_q;

   for (genvar i = 0; i < N_PIN; i++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pin_q[i] <= 1'b1;
            flag[i]  <= 1'b0;
         end else begin
            pin_q[i] <= pin_n[i];
            if (clr[i])
               flag[i] <= 1'b0;
            else if (edge_mode[i])
               flag[i] <= flag[i] | (pin_q[i] & ~pin_n[i]);
            else
               flag[i] <= ~pin_n[i];
         end
      end
   end
endmodule

// File: rtl/irq2_ovf_flags.sv
module irq2_ovf_flags #(
   parameter int unsigned N_TMR = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_TMR-1:0] set,
   input  logic [N_TMR-1:0] clr,
   output logic [N_TMR-1:0] flag
);
   generate
      if (N_TMR < 1) begin : g_bad
         $error("irq2_ovf_flags: N_TMR must be at least 1");
      end
   endgenerate

   // a fresh overflow in the acknowledge cycle is kept
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= '0;
      else        flag <= (flag & ~clr) | set;
   end
endmodule

// File: rtl/irq2_pick.sv
module irq2_pick
   import irq2_pkg::*;
(
   input  logic [SRC_N-1:0] pend,
   input  logic [SRC_N-1:0] hi,
   input  logic [1:0]       svc,
   output pick_t            pick
);
   logic [SRC_N-1:0] elig_hi, elig_lo;

   always_comb begin
      elig_hi = svc[1] ? '0 : (pend & hi);
      elig_lo = (svc != 2'b00) ? '0 : (pend & ~hi);
      pick    = '0;
      // scan downward so the lowest index is the last writer
      for (int k = SRC_N - 1; k >= 0; k--) begin
         if (elig_lo[k]) begin
            pick.hit = 1'b1;
            pick.idx = IDX_W'(k);
            pick.lvl = 1'b0;
         end
      end
      for (int k = SRC_N - 1; k >= 0; k--) begin
         if (elig_hi[k]) begin
            pick.hit = 1'b1;
            pick.idx = IDX_W'(k);
            pick.lvl = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq2_svc.sv
module irq2_svc (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take,
   input  logic       take_lvl,
   input  logic       ret,
   output logic [1:0] svc
);
   logic [1:0] after_ret;

   always_comb begin
      after_ret = svc;
      if (ret) begin
         if (svc[1]) after_ret[1] = 1'b0;
         else        after_ret[0] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    svc <= 2'b00;
      else if (take) svc <= after_ret | (take_lvl ? 2'b10 : 2'b01);
      else           svc <= after_ret;
   end
endmodule

// File: rtl/irq2_ctrl.sv
module irq2_ctrl
   import irq2_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned VEC_BASE   = 3,
   parameter int unsigned VEC_STRIDE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_en,
   input  logic [5:0]        src_en,
   input  logic [5:0]        src_hi,
   input  logic [1:0]        ext_n,
   input  logic [1:0]        ext_edge,
   input  logic [1:0]        tmr_ovf,
   input  logic              ser_req,
   input  logic              t2_req,
   input  logic              last_cycle,
   input  logic              ret_or_cfg,
   input  logic              irq_ack,
   input  logic              irq_ret,
   output logic              irq_req,
   output logic [ADDR_W-1:0] irq_vec,
   output logic [1:0]        insvc
);
   localparam longint unsigned TOP_VEC = longint'(VEC_BASE) + longint'(VEC_STRIDE) * (SRC_N - 1);
   localparam logic [ADDR_W-1:0] BASE_L   = ADDR_W'(VEC_BASE);
   localparam logic [ADDR_W-1:0] STRIDE_L = ADDR_W'(VEC_STRIDE);

   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_w
         $error("irq2_ctrl: ADDR_W out of range");
      end
      if (TOP_VEC >= (64'd1 << ADDR_W)) begin : g_bad_vec
         $error("irq2_ctrl: vector table does not fit ADDR_W");
      end
      if (VEC_STRIDE == 0) begin : g_bad_stride
         $error("irq2_ctrl: VEC_STRIDE must be nonzero");
      end
   endgenerate

   logic [1:0]       ext_flag, ovf_flag, ext_clr, ovf_clr;
   logic [SRC_N-1:0] flags, pend;
   pick_t            pick;
   logic             allowed, take;

   irq2_ext_latch #(.N_PIN(2)) u_ext (
      .clk(clk), .rst_n(rst_n), .pin_n(ext_n), .edge_mode(ext_edge),
      .clr(ext_clr), .flag(ext_flag)
   );

   irq2_ovf_flags #(.N_TMR(2)) u_ovf (
      .clk(clk), .rst_n(rst_n), .set(tmr_ovf), .clr(ovf_clr), .flag(ovf_flag)
   );

   always_comb begin
      flags          = '0;
      flags[SRC_X0]  = ext_flag[0];
      flags[SRC_TM0] = ovf_flag[0];
      flags[SRC_X1]  = ext_flag[1];
      flags[SRC_TM1] = ovf_flag[1];
      flags[SRC_SER] = ser_req;
      flags[SRC_TM2] = t2_req;
      pend           = master_en ? (flags & src_en) : '0;
   end

   irq2_pick u_pick (.pend(pend), .hi(src_hi), .svc(insvc), .pick(pick));

   assign allowed = last_cycle & ~ret_or_cfg;
   assign irq_req = pick.hit & allowed;
   assign irq_vec = irq_req ? (BASE_L + STRIDE_L * ADDR_W'(pick.idx)) : '0;
   assign take    = irq_ack & irq_req;

   // hardware clearing applies only to the pin and overflow slots
   assign ext_clr[0] = take && (pick.idx == SRC_X0);
   assign ext_clr[1] = take && (pick.idx == SRC_X1);
   assign ovf_clr[0] = take && (pick.idx == SRC_TM0);
   assign ovf_clr[1] = take && (pick.idx == SRC_TM1);

   irq2_svc u_svc (
      .clk(clk), .rst_n(rst_n), .take(take), .take_lvl(pick.lvl),
      .ret(irq_ret), .svc(insvc)
   );
endmodule

// File: rtl/irq2_ctrl_chk.sv
module irq2_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       master_en,
   input logic       last_cycle,
   input logic       ret_or_cfg,
   input logic       irq_ack,
   input logic       irq_ret,
   input logic       irq_req,
   input logic [1:0] insvc
);
   p_gate_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !master_en |-> !irq_req);

   p_defer_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!last_cycle || ret_or_cfg) |-> !irq_req);

   p_hi_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      insvc[1] |-> !irq_req);

   p_take_marks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req && !irq_ret) |=> (insvc != 2'b00));

   p_ret_retires_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && !irq_ack && insvc == 2'b01) |=> (insvc == 2'b00));

   p_svc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_ack && !irq_ret) |=> $stable(insvc));
endmodule

bind irq2_ctrl irq2_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .master_en(master_en), .last_cycle(last_cycle),
   .ret_or_cfg(ret_or_cfg), .irq_ack(irq_ack), .irq_ret(irq_ret),
   .irq_req(irq_req), .insvc(insvc)
);

// File: tb/irq2_ctrl_tb.sv
`timescale 1ns/100ps
module irq2_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        master_en = 1'b1;
   logic [5:0]  src_en = 6'h3F, src_hi = 6'h00;
   logic [1:0]  ext_n = 2'b11, ext_edge = 2'b00, tmr_ovf = 2'b00;
   logic        ser_req = 1'b0, t2_req = 1'b0;
   logic        last_cycle = 1'b1, ret_or_cfg = 1'b0;
   logic        irq_ack = 1'b0, irq_ret = 1'b0;
   logic        irq_req;
   logic [15:0] irq_vec;
   logic [1:0]  insvc;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   typedef struct {
      string       tag;
      logic        req;
      logic [15:0] vec;
      logic [1:0]  svc;
   } exp_t;
   exp_t sb[$];
   event ev_chk;

   always #2 clk = ~clk;   // 250 MHz

   irq2_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .master_en(master_en), .src_en(src_en),
      .src_hi(src_hi), .ext_n(ext_n), .ext_edge(ext_edge), .tmr_ovf(tmr_ovf),
      .ser_req(ser_req), .t2_req(t2_req), .last_cycle(last_cycle),
      .ret_or_cfg(ret_or_cfg), .irq_ack(irq_ack), .irq_ret(irq_ret),
      .irq_req(irq_req), .irq_vec(irq_vec), .insvc(insvc)
   );

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         @(ev_chk);
         while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (irq_req !== e.req || irq_vec !== e.vec || insvc !== e.svc) begin
               n_err++;
               $display("FAIL %s: got req=%b vec=%h svc=%b, expected req=%b vec=%h svc=%b",
                        e.tag, irq_req, irq_vec, insvc, e.req, e.vec, e.svc);
            end
         end
      end
   end

   task automatic expect_out(input string tag, input logic req,
                             input logic [15:0] vec, input logic [1:0] svc);
      exp_t e;
      #1;
      e.tag = tag; e.req = req; e.vec = vec; e.svc = svc;
      sb.push_back(e);
      -> ev_chk;
      #0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_ack();
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
   endtask

   task automatic pulse_ret();
      irq_ret = 1'b1; ret_or_cfg = 1'b1; tick(); irq_ret = 1'b0; ret_or_cfg = 1'b0;
   endtask

   task automatic pulse_ovf(input logic [1:0] which);
      tmr_ovf = which; tick(); tmr_ovf = 2'b00;
   endtask

   // watchdog
   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      expect_out("R11 reset", 1'b0, 16'h0000, 2'b00);
      rst_n = 1'b1;
      tick();
      expect_out("R11 after reset", 1'b0, 16'h0000, 2'b00);

      // R2 gating, R1 serial vector, R8 persistence
      ser_req = 1'b1; master_en = 1'b0;
      expect_out("R2 global off", 1'b0, 16'h0000, 2'b00);
      master_en = 1'b1; src_en[4] = 1'b0;
      expect_out("R2 source off", 1'b0, 16'h0000, 2'b00);
      src_en[4] = 1'b1;
      expect_out("R1 serial vector", 1'b1, 16'h0023, 2'b00);
      t2_req = 1'b1;
      expect_out("R3 serial before t2", 1'b1, 16'h0023, 2'b00);
      pulse_ack();
      expect_out("R4 low blocks low, R10 low set", 1'b0, 16'h0000, 2'b01);
      irq_ret = 1'b1; ret_or_cfg = 1'b1;
      expect_out("R9 return defers", 1'b0, 16'h0000, 2'b01);
      tick(); irq_ret = 1'b0; ret_or_cfg = 1'b0;
      expect_out("R8 serial not cleared", 1'b1, 16'h0023, 2'b00);
      ser_req = 1'b0;
      expect_out("R1 t2 vector", 1'b1, 16'h002B, 2'b00);
      t2_req = 1'b0;
      expect_out("R8 idle", 1'b0, 16'h0000, 2'b00);

      // R7 timer flags, R3 order
      pulse_ovf(2'b10);
      expect_out("R7 t1 latched", 1'b1, 16'h001B, 2'b00);
      pulse_ovf(2'b01);
      expect_out("R3 t0 before t1", 1'b1, 16'h000B, 2'b00);
      pulse_ack();
      expect_out("R10 ack t0", 1'b0, 16'h0000, 2'b01);
      pulse_ret();
      expect_out("R7 t0 cleared t1 kept", 1'b1, 16'h001B, 2'b00);
      pulse_ack();
      pulse_ret();
      expect_out("R7 t1 cleared", 1'b0, 16'h0000, 2'b00);

      // R3/R4 priority levels and preemption
      src_hi[3] = 1'b1;
      pulse_ovf(2'b11);
      expect_out("R3 high t1 over low t0", 1'b1, 16'h001B, 2'b00);
      pulse_ack();
      expect_out("R4 high blocks all", 1'b0, 16'h0000, 2'b10);
      pulse_ret();
      expect_out("R10 high retired", 1'b1, 16'h000B, 2'b00);
      pulse_ack();
      expect_out("R10 low in service", 1'b0, 16'h0000, 2'b01);
      pulse_ovf(2'b10);
      expect_out("R4 high preempts low", 1'b1, 16'h001B, 2'b01);
      pulse_ack();
      expect_out("R10 both levels", 1'b0, 16'h0000, 2'b11);
      pulse_ret();
      expect_out("R10 return clears high first", 1'b0, 16'h0000, 2'b01);
      pulse_ret();
      expect_out("R10 return clears low", 1'b0, 16'h0000, 2'b00);
      src_hi[3] = 1'b0;

      // R5 level mode on pin 0
      ext_n[0] = 1'b0;
      expect_out("R5 not before edge", 1'b0, 16'h0000, 2'b00);
      tick();
      expect_out("R5 level request", 1'b1, 16'h0003, 2'b00);
      pulse_ack();
      expect_out("R5 acked", 1'b0, 16'h0000, 2'b01);
      pulse_ret();
      expect_out("R5 reasserts while low", 1'b1, 16'h0003, 2'b00);
      ext_n[0] = 1'b1;
      tick();
      expect_out("R5 follows pin high", 1'b0, 16'h0000, 2'b00);

      // R6 edge mode on pin 1
      ext_edge[1] = 1'b1;
      ext_n[1] = 1'b0;
      tick();
      expect_out("R6 falling edge", 1'b1, 16'h0013, 2'b00);
      ext_n[1] = 1'b1;
      tick();
      expect_out("R6 held after pin high", 1'b1, 16'h0013, 2'b00);
      pulse_ack();
      pulse_ret();
      expect_out("R6 cleared by ack", 1'b0, 16'h0000, 2'b00);

      // R9 deferral
      ext_n[1] = 1'b0;
      tick();
      last_cycle = 1'b0;
      expect_out("R9 not last cycle", 1'b0, 16'h0000, 2'b00);
      last_cycle = 1'b1;
      expect_out("R9 released", 1'b1, 16'h0013, 2'b00);
      ret_or_cfg = 1'b1;
      expect_out("R9 config access", 1'b0, 16'h0000, 2'b00);
      ret_or_cfg = 1'b0;
      expect_out("R9 released again", 1'b1, 16'h0013, 2'b00);

      done = 1;
      #1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule